// File: doc/BRIEF.md
# Refresh Cycle Detector with Self-Advancing Row Counter

This block sits on the device side of a dynamic memory. It watches the active-low row strobe, column strobe and write-enable inputs, and it decides on each falling edge of the row strobe what kind of cycle the controller has started. If the column strobe was already low and write-enable is high, the cycle is a column-before-row refresh. The block then refreshes the row held in a private counter and advances that counter by one. If the column strobe is high, the cycle is a row-only refresh, and the row comes from the address pins. If the column strobe and write-enable are both low, the cycle is illegal. It raises a flag and refreshes nothing.

All strobe and address inputs pass through a synchroniser of parameterised depth before classification. The result is registered, so each falling edge of the row strobe gives exactly one single-cycle pulse. The controller cannot clear the internal counter. The counter takes a seed value at power-on, wraps on its own at the end of the row range, and keeps its value through a functional reset. The memory array and the normal read and write paths are not part of this block.

Top module: `rfd_cbr_refresh`

## Requirements
- R1: While reset is asserted and after it is released with no strobe activity, `ref_stb`, `illegal_stb`, `ref_from_ctr` and `ref_row` are all 0.
- R2: A falling row strobe with `cas_n`=0 and `we_n`=1 gives one `ref_stb` pulse with `ref_from_ctr`=1, and `ref_row` equals the current counter value.
- R3: After each column-before-row refresh, the counter advances by one, so back-to-back refreshes of that kind report consecutive rows.
- R4: The counter goes from ROW_COUNT-1 to 0 and never holds a value above ROW_COUNT-1.
- R5: After power-on the counter holds CTR_SEED. Asserting `rst_n` does not change it, so the first refresh after a reset continues the sequence.
- R6: During a column-before-row refresh, `row_addr` has no effect on `ref_row`.
- R7: A falling row strobe with `cas_n`=1 gives one `ref_stb` pulse with `ref_from_ctr`=0 and `ref_row` equal to `row_addr`, and it leaves the counter unchanged.
- R8: Each falling row strobe gives exactly one single-cycle pulse, SYNC_STAGES+1 clock cycles after the edge is first sampled. A rising edge, or holding the strobe low, gives no pulse.
- R9: A falling row strobe with `cas_n`=0 and `we_n`=0 gives one `illegal_stb` pulse and no `ref_stb`, and it leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low functional reset (does not touch the row counter) |
| ras_n | input | 1 | Active-low row strobe, asynchronous |
| cas_n | input | 1 | Active-low column strobe, asynchronous |
| we_n | input | 1 | Active-low write enable, asynchronous |
| row_addr | input | ROW_W | Row address pins |
| ref_stb | output | 1 | Single-cycle refresh pulse |
| ref_row | output | ROW_W | Row to refresh, valid with `ref_stb` and held afterwards |
| ref_from_ctr | output | 1 | 1 when `ref_row` came from the internal counter |
| illegal_stb | output | 1 | Single-cycle pulse for a cycle with column strobe and write-enable both low |

## Verification
The bench builds the block with a 4-bit row and ROW_COUNT of 12, so the counter uses the compare-and-clear wrap path rather than the natural binary rollover. A seed of 9 brings the wrap from 11 to 0 within three refreshes. SYNC_STAGES is 2, so the pulse is due in the third cycle after the row strobe falls, and the bench samples it there. With these values, the seed, the wrap, the survival of the counter across a functional reset, and the counter being left alone by row-only and illegal cycles are all visible within a few dozen cycles.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

   // Kind of cycle decoded on a falling row strobe
   typedef enum logic [1:0] {
      CYC_NONE     = 2'd0,
      CYC_CBR      = 2'd1,
      CYC_RAS_ONLY = 2'd2,
      CYC_ILLEGAL  = 2'd3
   } cyc_kind_e;

endpackage

// File: rtl/rfd_sync.sv
module rfd_sync #(
   parameter int          W         = 1,
   parameter int          STAGES    = 2,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rfd_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("rfd_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RESET_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rfd_classify.sv
module rfd_classify
   import rfd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ras_n_s,
   input  logic      cas_n_s,
   input  logic      we_n_s,
   output cyc_kind_e kind
);

   logic ras_prev_q;
   logic ras_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ras_prev_q <= 1'b1;
      else        ras_prev_q <= ras_n_s;
   end

   assign ras_fall = ras_prev_q & ~ras_n_s;

   always_comb begin
      kind = CYC_NONE;
      if (ras_fall) begin
         if (cas_n_s)     kind = CYC_RAS_ONLY;
         else if (we_n_s) kind = CYC_CBR;
         else             kind = CYC_ILLEGAL;
      end
   end

   AST_KIND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != CYC_NONE) |=> (kind == CYC_NONE)); // R8

endmodule

// File: rtl/rfd_row_counter.sv
module rfd_row_counter #(
   parameter int ROW_W     = 10,
   parameter int ROW_COUNT = 1024,
   parameter int CTR_SEED  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ROW_W-1:0] row
);

   localparam int             FULL_RANGE = 2 ** ROW_W;
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_COUNT - 1);
   localparam logic [ROW_W-1:0] SEED_ROW = ROW_W'(CTR_SEED);

   generate
      if (ROW_COUNT < 2 || ROW_COUNT > FULL_RANGE) begin : g_bad_count
         $error("rfd_row_counter: ROW_COUNT must lie in 2..2**ROW_W");
      end
      if (CTR_SEED < 0 || CTR_SEED >= ROW_COUNT) begin : g_bad_seed
         $error("rfd_row_counter: CTR_SEED must lie in 0..ROW_COUNT-1");
      end
   endgenerate

   // Power-on value only; the functional reset never touches it.
   logic [ROW_W-1:0] ctr_q = SEED_ROW;
   logic [ROW_W-1:0] ctr_next;

   generate
      if (ROW_COUNT == FULL_RANGE) begin : g_wrap_natural
         assign ctr_next = ctr_q + 1'b1;
      end else begin : g_wrap_compare
         assign ctr_next = (ctr_q == LAST_ROW) ? '0 : ctr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (inc) ctr_q <= ctr_next;
   end

   assign row = ctr_q;

   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(ctr_q)); // R7
   AST_CTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_q <= LAST_ROW); // R4
   AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && ctr_q == LAST_ROW) |=> (ctr_q == '0)); // R4

endmodule

// File: rtl/rfd_cbr_refresh.sv
module rfd_cbr_refresh
   import rfd_pkg::*;
#(
   parameter int ROW_W       = 10,
   parameter int ROW_COUNT   = 1024,
   parameter int CTR_SEED    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [ROW_W-1:0] row_addr,
   output logic             ref_stb,
   output logic [ROW_W-1:0] ref_row,
   output logic             ref_from_ctr,
   output logic             illegal_stb
);

   localparam int             BUS_W     = ROW_W + 3;
   localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {ROW_W{1'b0}}};

   logic [BUS_W-1:0] bus_s;
   logic             ras_n_s, cas_n_s, we_n_s;
   logic [ROW_W-1:0] addr_s;
   logic [ROW_W-1:0] ctr_row;
   cyc_kind_e        kind;
   logic             ctr_inc;

   // Strobes and address share one synchroniser so they stay aligned
   rfd_sync #(
      .W         (BUS_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (BUS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ras_n, cas_n, we_n, row_addr}),
      .q     (bus_s)
   );

   assign {ras_n_s, cas_n_s, we_n_s, addr_s} = bus_s;

   rfd_classify u_classify (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_n_s (ras_n_s),
      .cas_n_s (cas_n_s),
      .we_n_s  (we_n_s),
      .kind    (kind)
   );

   assign ctr_inc = (kind == CYC_CBR);

   rfd_row_counter #(
      .ROW_W     (ROW_W),
      .ROW_COUNT (ROW_COUNT),
      .CTR_SEED  (CTR_SEED)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc),
      .row   (ctr_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_stb      <= 1'b0;
         ref_row      <= '0;
         ref_from_ctr <= 1'b0;
         illegal_stb  <= 1'b0;
      end else begin
         ref_stb     <= (kind == CYC_CBR) || (kind == CYC_RAS_ONLY);
         illegal_stb <= (kind == CYC_ILLEGAL);
         if (kind == CYC_CBR) begin
            ref_row      <= ctr_row;
            ref_from_ctr <= 1'b1;
         end else if (kind == CYC_RAS_ONLY) begin
            ref_row      <= addr_s;
            ref_from_ctr <= 1'b0;
         end
      end
   end

   AST_STB_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb |=> !ref_stb); // R8
   AST_ILLEGAL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_stb |=> !illegal_stb); // R9
   AST_NO_REFRESH_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_stb && illegal_stb)); // R9
   AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_stb |=> $stable(ref_row) || ref_stb); // R2

endmodule

// File: tb/rfd_cbr_refresh_bench.sv
module rfd_cbr_refresh_bench;

   localparam int ROW_W = 4;
   localparam int ROW_COUNT = 12;
   localparam int SEED = 9;
   localparam int SYNC = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1;
   logic             cas_n = 1'b1;
   logic             we_n = 1'b1;
   logic [ROW_W-1:0] row_addr = '0;
   logic             ref_stb;
   logic [ROW_W-1:0] ref_row;
   logic             ref_from_ctr;
   logic             illegal_stb;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rfd_cbr_refresh #(
      .ROW_W       (ROW_W),
      .ROW_COUNT   (ROW_COUNT),
      .CTR_SEED    (SEED),
      .SYNC_STAGES (SYNC)
   ) u_rfd_cbr_refresh (
      .clk          (clk),
      .rst_n        (rst_n),
      .ras_n        (ras_n),
      .cas_n        (cas_n),
      .we_n         (we_n),
      .row_addr     (row_addr),
      .ref_stb      (ref_stb),
      .ref_row      (ref_row),
      .ref_from_ctr (ref_from_ctr),
      .illegal_stb  (illegal_stb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kind: 0 refresh from counter, 1 refresh from pins, 2 illegal
   task automatic run_cycle(input bit c_n, input bit w_n, input int addr,
                            input int kind, input int exp_row, input string req);
      int stb_cnt = 0;
      int ill_cnt = 0;
      @(negedge clk);
      cas_n = c_n; we_n = w_n; row_addr = ROW_W'(addr);
      repeat (2) @(negedge clk);
      ras_n = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (i == SYNC + 1) begin
            if (kind == 2) begin
               chk(illegal_stb == 1'b1, {req, " R9 illegal pulse"}, illegal_stb, 1);
               chk(ref_stb == 1'b0, {req, " R9 no refresh"}, ref_stb, 0);
            end else begin
               chk(ref_stb == 1'b1, {req, " R8 pulse timing"}, ref_stb, 1);
               chk(ref_row == ROW_W'(exp_row), {req, " row"}, ref_row, exp_row);
               chk(ref_from_ctr == (kind == 0), {req, " source flag"},
                   ref_from_ctr, (kind == 0) ? 1 : 0);
            end
         end
         stb_cnt += ref_stb;
         ill_cnt += illegal_stb;
      end
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         stb_cnt += ref_stb;
         ill_cnt += illegal_stb;
      end
      chk(stb_cnt == ((kind == 2) ? 0 : 1), {req, " R8 refresh pulse count"},
          stb_cnt, (kind == 2) ? 0 : 1);
      chk(ill_cnt == ((kind == 2) ? 1 : 0), {req, " R8 illegal pulse count"},
          ill_cnt, (kind == 2) ? 1 : 0);
   endtask

   task automatic t_reset_state();
      chk(ref_stb == 1'b0, "R1 ref_stb in reset", ref_stb, 0);
      chk(illegal_stb == 1'b0, "R1 illegal in reset", illegal_stb, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ref_stb == 1'b0 && illegal_stb == 1'b0, "R1 strobes idle", ref_stb, 0);
      chk(ref_row == '0, "R1 row cleared", ref_row, 0);
      chk(ref_from_ctr == 1'b0, "R1 source flag cleared", ref_from_ctr, 0);
   endtask

   task automatic t_seed_and_step();
      run_cycle(1'b0, 1'b1, 3, 0, SEED, "R5 seed R2 first");
      run_cycle(1'b0, 1'b1, 3, 0, SEED + 1, "R3 step");
      run_cycle(1'b0, 1'b1, 3, 0, SEED + 2, "R3 step to last");
   endtask

   task automatic t_wrap();
      run_cycle(1'b0, 1'b1, 7, 0, 0, "R4 wrap to zero");
      run_cycle(1'b0, 1'b1, 7, 0, 1, "R4 after wrap");
   endtask

   task automatic t_ras_only();
      run_cycle(1'b1, 1'b1, 5, 1, 5, "R7 pin row");
      run_cycle(1'b1, 1'b0, 14, 1, 14, "R7 pin row we low");
      run_cycle(1'b0, 1'b1, 0, 0, 2, "R7 counter untouched");
   endtask

   task automatic t_illegal();
      run_cycle(1'b0, 1'b0, 6, 2, 0, "R9 illegal cycle");
      run_cycle(1'b0, 1'b1, 6, 0, 3, "R9 counter untouched");
   endtask

   task automatic t_reset_keeps_counter();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(ref_stb == 1'b0, "R1 strobe low in mid-run reset", ref_stb, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_cycle(1'b0, 1'b1, 0, 0, 4, "R5 counter survives reset");
   endtask

   task automatic t_addr_ignored();
      run_cycle(1'b0, 1'b1, 15, 0, 5, "R6 pins ignored a");
      run_cycle(1'b0, 1'b1, 10, 0, 6, "R6 pins ignored b");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_seed_and_step();
      t_wrap();
      t_ras_only();
      t_illegal();
      t_reset_keeps_counter();
      t_addr_ignored();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule